// File: doc/BRIEF.md
# Transmit Parity Error Monitor

This block belongs to the sending end of a point-to-point serial frame link. For every outgoing frame it produces one parity bit over the header and data fields together. The parity sense can be set to even or odd. The far end accepts only even parity, so choosing odd parity on purpose makes the far end reply with an error. That reply is useful during link bring-up, when the loop delay of the link is being measured.

The far end reports a parity error by pulling the ready line low for a short time after the frame ends. The monitor opens a detection window when the frame-valid strobe falls. The window length is programmable and is captured at the moment the window opens. If ready is seen low inside the window, three things happen:

- a sticky error flag is set;
- a budget counter of tolerated errors is decremented;
- when the budget is used up, an event pulse is produced and a pending interrupt flag is set.

The service request output follows the pending flag only while the interrupt enable is high.

Top module: `parity_err_monitor`

## Requirements
- R1: With `odd_sel_i` = 0, `parity_o` is 1 exactly when the number of 1-bits in `{hdr_i, data_i}` is odd. This is combinational.
- R2: With `odd_sel_i` = 1, `parity_o` is 1 exactly when the number of 1-bits in `{hdr_i, data_i}` is even.
- R3: Let edge k be the clock edge at which `valid_i` is first sampled 0 after being 1, and let N = `win_len_i` at edge k. If `ready_i` is sampled 0 at one of the edges k+1 .. k+N, that edge counts as one error. At most one error is counted per window.
- R4: `ready_i` at 0 outside the window, or after the window has already recorded its error, changes no output. A window in which ready stays 1 changes no output.
- R5: Each error sets `err_flag_o` and decrements `budget_o` by 1 at the same edge. The budget holds at 0 and never wraps.
- R6: An error fires a one-cycle `event_o` pulse and sets `irq_pend_o` when `budget_o` was 1 or 0 before that error.
- R7: `srq_o` is 1 exactly when `irq_pend_o` = 1 and `irq_en_i` = 1.
- R8: `err_clr_i` clears `err_flag_o`, and `irq_clr_i` clears `irq_pend_o`. A set caused by an error at the same edge wins over the clear.
- R9: Changing `win_len_i` after edge k does not change the length of the window that is already open.
- R10: `budget_ld_i` loads `budget_i`, saturated to BUDGET_MAX (16). A load takes priority over a decrement at the same edge.
- R11: After reset, `err_flag_o`, `irq_pend_o`, `event_o` and `srq_o` are 0, and `budget_o` is BUDGET_MAX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hdr_i | input | HDR_W | Frame header bits |
| data_i | input | DATA_W | Frame data bits |
| odd_sel_i | input | 1 | 1 selects odd parity |
| parity_o | output | 1 | Parity bit for the frame |
| valid_i | input | 1 | Frame-valid strobe |
| ready_i | input | 1 | Ready line from the receiver; low inside the window means an error |
| win_len_i | input | WIN_W | Detection window length in cycles |
| budget_ld_i | input | 1 | Load the budget counter |
| budget_i | input | CNT_W | Budget value to load |
| err_clr_i | input | 1 | Clear the sticky error flag |
| irq_clr_i | input | 1 | Clear the pending interrupt flag |
| irq_en_i | input | 1 | Interrupt enable |
| err_flag_o | output | 1 | Sticky parity error flag |
| irq_pend_o | output | 1 | Pending interrupt flag |
| event_o | output | 1 | One-cycle parity error event pulse |
| srq_o | output | 1 | Gated service request |
| budget_o | output | CNT_W | Remaining error budget |

## Verification
Two functions can act at the same edge: the error that sets the sticky flag and the pending flag, and a software clear of those same flags. The bench provokes this by asserting both clear inputs in exactly the cycle in which ready is driven low inside a window. It expects the flags to stay set, and to stay set only where the budget rules allow an event. In other frames it asserts the clears on a quiet cycle and expects them to take effect. A bench model tracks budget, flags and event count arithmetically. It is compared after every frame of a sweep over window lengths and error offsets, including offsets just past the window.

// File: rtl/parity_err_monitor.sv
module parity_err_monitor #(
  parameter int HDR_W      = 4,
  parameter int DATA_W     = 8,
  parameter int WIN_W      = 4,
  parameter int BUDGET_MAX = 16,
  localparam int CNT_W     = $clog2(BUDGET_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HDR_W-1:0]  hdr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              odd_sel_i,
  output logic              parity_o,
  input  logic              valid_i,
  input  logic              ready_i,
  input  logic [WIN_W-1:0]  win_len_i,
  input  logic              budget_ld_i,
  input  logic [CNT_W-1:0]  budget_i,
  input  logic              err_clr_i,
  input  logic              irq_clr_i,
  input  logic              irq_en_i,
  output logic              err_flag_o,
  output logic              irq_pend_o,
  output logic              event_o,
  output logic              srq_o,
  output logic [CNT_W-1:0]  budget_o
);

  localparam logic [CNT_W-1:0] CAP = CNT_W'(BUDGET_MAX);

  logic             valid_q;
  logic             armed;
  logic [WIN_W-1:0] win_left;
  logic [CNT_W-1:0] budget_q;
  logic             flag_q, pend_q, evt_q;

  wire fall    = valid_q & ~valid_i;
  wire err_hit = armed & ~ready_i;
  wire fire    = err_hit & (budget_q <= CNT_W'(1));

  assign parity_o   = (^{hdr_i, data_i}) ^ odd_sel_i;
  assign err_flag_o = flag_q;
  assign irq_pend_o = pend_q;
  assign event_o    = evt_q;
  assign srq_o      = pend_q & irq_en_i;
  assign budget_o   = budget_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      armed    <= 1'b0;
      win_left <= '0;
    end else begin
      valid_q <= valid_i;
      if (fall) begin
        armed    <= (win_len_i != '0);
        win_left <= win_len_i;
      end else if (armed) begin
        if (!ready_i || win_left == WIN_W'(1)) armed <= 1'b0;
        win_left <= win_left - WIN_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      budget_q <= CAP;
    end else if (budget_ld_i) begin
      budget_q <= (budget_i > CAP) ? CAP : budget_i;
    end else if (err_hit && budget_q != '0) begin
      budget_q <= budget_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      pend_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      evt_q <= fire;
      if (err_hit)        flag_q <= 1'b1;
      else if (err_clr_i) flag_q <= 1'b0;
      if (fire)           pend_q <= 1'b1;
      else if (irq_clr_i) pend_q <= 1'b0;
    end
  end

endmodule

// File: rtl/parity_err_monitor_chk.sv
module parity_err_monitor_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             armed,
  input logic             ready_i,
  input logic             budget_ld_i,
  input logic             err_clr_i,
  input logic             err_flag_o,
  input logic             irq_pend_o,
  input logic             event_o,
  input logic [CNT_W-1:0] budget_o
);

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag_o && !err_clr_i) |=> err_flag_o); // R5

  AST_EVENT_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    event_o |-> irq_pend_o); // R6

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!budget_ld_i && budget_o == '0) |=> budget_o == '0); // R5

  AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !ready_i && !budget_ld_i && budget_o != '0)
      |=> budget_o == $past(budget_o) - CNT_W'(1)); // R5

  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(armed && !ready_i) && !budget_ld_i) |=> $stable(budget_o)); // R4

  AST_EVENT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!(armed && !ready_i)) |=> !event_o); // R6

  AST_ERR_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !ready_i) |=> err_flag_o); // R8

endmodule

bind parity_err_monitor parity_err_monitor_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .armed(armed), .ready_i(ready_i),
  .budget_ld_i(budget_ld_i), .err_clr_i(err_clr_i),
  .err_flag_o(err_flag_o), .irq_pend_o(irq_pend_o),
  .event_o(event_o), .budget_o(budget_o)
);

// File: tb/tb_parity_err_monitor.sv
`timescale 1ns/1ps
module tb_parity_err_monitor;
  localparam int HDR_W = 4, DATA_W = 8, WIN_W = 4, BMAX = 16, CNT_W = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [HDR_W-1:0] hdr = '0;
  logic [DATA_W-1:0] data = '0;
  logic odd_sel = 1'b0, parity, valid = 1'b0, ready = 1'b1;
  logic [WIN_W-1:0] win_len = '0;
  logic bld = 1'b0;
  logic [CNT_W-1:0] bval = '0;
  logic eclr = 1'b0, iclr = 1'b0, ien = 1'b0;
  logic eflag, ipend, evt, srq;
  logic [CNT_W-1:0] budget;

  int vecs = 0, errs = 0;
  int bud = BMAX, evexp = 0, evseen = 0;
  bit flag = 0, pend = 0;

  always #5 clk = ~clk;

  parity_err_monitor #(.HDR_W(HDR_W), .DATA_W(DATA_W), .WIN_W(WIN_W), .BUDGET_MAX(BMAX)) dut (
    .clk(clk), .rst_n(rst_n), .hdr_i(hdr), .data_i(data), .odd_sel_i(odd_sel),
    .parity_o(parity), .valid_i(valid), .ready_i(ready), .win_len_i(win_len),
    .budget_ld_i(bld), .budget_i(bval), .err_clr_i(eclr), .irq_clr_i(iclr),
    .irq_en_i(ien), .err_flag_o(eflag), .irq_pend_o(ipend), .event_o(evt),
    .srq_o(srq), .budget_o(budget));

  task automatic chk(input string req, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_state(input string tag);
    chk({tag, " R5 budget"}, budget, bud);
    chk({tag, " R5 flag"}, eflag, flag);
    chk({tag, " R6 pend"}, ipend, pend);
    chk({tag, " R7 srq"}, srq, pend & ien);
  endtask

  task automatic load(input int v);
    bld = 1'b1; bval = CNT_W'(v);
    @(negedge clk);
    bld = 1'b0;
    bud = (v > BMAX) ? BMAX : v;
  endtask

  // w: window length, off: cycle after the fall with ready low, clr_at: cycle with clears
  task automatic frame(input int w, input int off, input int clr_at);
    bit e, ev;
    valid = 1'b1; win_len = WIN_W'(w);
    @(negedge clk);
    valid = 1'b0;
    @(negedge clk);
    win_len = '1; // R9: a late change must not stretch the window
    evexp = 0; evseen = 0;
    for (int i = 1; i <= w + 3; i++) begin
      ready = (i != off);
      eclr = (i == clr_at); iclr = (i == clr_at);
      @(negedge clk);
      if (evt) evseen++;
      e = (off <= w) && (i == off);
      ev = e && (bud <= 1);
      if (e) begin
        flag = 1; bud = (bud > 0) ? bud - 1 : 0;
        if (ev) begin pend = 1; evexp++; end
      end
      if (i == clr_at) begin
        if (!e) flag = 0;
        if (!ev) pend = 0;
      end
    end
    ready = 1'b1; eclr = 1'b0; iclr = 1'b0;
    @(negedge clk);
    if (evt) evseen++;
    chk("R3 R4 R6 event count", evseen, evexp);
  endtask

  initial begin
    #1_000_000;
    errs++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 flag", eflag, 0);
    chk("R11 pend", ipend, 0);
    chk("R11 event", evt, 0);
    chk("R11 srq", srq, 0);
    chk("R11 budget", budget, BMAX);

    for (int h = 0; h < (1 << HDR_W); h++)
      for (int d = 0; d < (1 << DATA_W); d++)
        for (int o = 0; o < 2; o++) begin
          hdr = HDR_W'(h); data = DATA_W'(d); odd_sel = o[0];
          #1;
          if (o == 0) chk("R1 even parity", parity, $countones({hdr, data}) % 2);
          else        chk("R2 odd parity", parity, 1 - ($countones({hdr, data}) % 2));
        end

    load(31);
    chk("R10 saturated load", budget, BMAX);
    load(3);
    chk("R10 load", budget, 3);

    for (int w = 1; w <= 6; w++) begin
      for (int off = 1; off <= w + 2; off++) begin
        ien = off[0];
        frame(w, off, (w % 2 == 1) ? off : w + 3);
        check_state("R3 R8");
      end
      load(w);
      check_state("R10");
    end

    // error and reload at one edge: reload wins, event judged on the old budget
    load(1);
    valid = 1'b1; win_len = 4'd3;
    @(negedge clk);
    valid = 1'b0;
    @(negedge clk);
    ready = 1'b0; bld = 1'b1; bval = 5'd7;
    @(negedge clk);
    ready = 1'b1; bld = 1'b0;
    chk("R10 load beats decrement", budget, 7);
    chk("R6 event from old budget", evt, 1);
    chk("R5 flag on collision", eflag, 1);
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule